// File: doc/BRIEF.md
# Indexed Interrupt Enable Register Bank

This block holds the enable state of an interrupt controller that has 160 system-event inputs and 20 host-interrupt outputs. Software reaches it through a simple single-cycle register bus. Each enable bit can be changed in two ways. The first is to write a whole 32-bit bitmask to an enable word. The second is to write one bit number to a set-index or clear-index register. An index write changes exactly that bit. Software therefore never needs a read-modify-write, and two agents that share a word cannot undo each other's changes.

The block drives three outputs:
- a 160-bit event-enable vector, which downstream mapping logic consumes;
- a 20-bit host-enable vector;
- a 20-bit host-interrupt vector, in which each line is the pending request for that host gated by its host enable bit.

Top module: `irq_enable_bank`

## Requirements
- R1: While reset is low at a clock edge, and after it, every event enable bit and every host enable bit is zero, so every host interrupt output is low.
- R2: A bus write of N to the event-set register (word address 8) sets event enable bit N and leaves all other bits unchanged. Event N lives in event word N/32 at bit N%32.
- R3: A bus write of N to the host-set register (word address 10) sets host enable bit N and leaves all other bits unchanged.
- R4: A bus write of N to the event-clear register (word address 9) clears only event bit N. A bus write of N to the host-clear register (word address 11) clears only host bit N.
- R5: Only write-data bits 9:0 form the index, so bits 31:10 are ignored. An index above 159 on an event register, or above 19 on a host register, changes nothing.
- R6: A bus write to word addresses 0 to 4 loads event word 0 to 4 with the full 32-bit data. A bus write to word address 5 loads host bits 19:0 from data bits 19:0. Host word bits 31:20 always read zero.
- R7: Reads return the enable words at addresses 0 to 5. The four index registers read zero. Unmapped addresses (6, 7, 12 to 15) read zero.
- R8: Host interrupt output h is high exactly when request input h is high and host enable bit h is set.
- R9: A write takes effect on the clock edge that samples the write strobe high. With the strobe low, no enable bit changes, whatever the address and data are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_we | input | 1 | Write strobe, sampled on the rising edge |
| bus_addr | input | 4 | Word address for reads and writes |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| host_req_i | input | 20 | Pending request for each host interrupt |
| event_en_o | output | 160 | Enable bit of each system event |
| host_en_o | output | 20 | Enable bit of each host interrupt |
| host_irq_o | output | 20 | Host requests gated by their enables |

## Verification
The embedded properties check these rules on every cycle:
- an index write moves at most one bit of its bank;
- a set never lowers a bit, and a clear never raises one;
- an out-of-range index leaves the bank untouched;
- an idle strobe holds every bit;
- no host interrupt fires while its enable is clear;
- index registers always read zero.

Only the bench's scenarios can show that the right bit is the one that moved. They also show the index-to-word/bit placement at 0, 31, 32 and 159, the masking of upper index bits, the truncation of the host word, and that the random mix of word and index writes agrees with a reference model.

// File: rtl/irqen_pkg.sv
// Package irqen_pkg
// Shared constants for the indexed interrupt enable bank: the bus
// address map and data width. Assumes a word-addressed register bus.
package irqen_pkg;
    localparam int DATA_W        = 32;
    localparam int ADDR_W        = 4;
    localparam int IDX_W         = 10;
    // Event enable words occupy consecutive addresses from this base.
    localparam int EVT_WORD_BASE = 0;
    localparam int HOST_WORD     = 5;
    localparam int EVT_SET_IDX   = 8;
    localparam int EVT_CLR_IDX   = 9;
    localparam int HOST_SET_IDX  = 10;
    localparam int HOST_CLR_IDX  = 11;

    // Number of bus words needed to hold a given number of enable bits.
    function automatic int words_for(input int nbits);
        return (nbits + DATA_W - 1) / DATA_W;
    endfunction
endpackage

// File: rtl/irqen_decode.sv
// Module irqen_decode
// Turns one bus write into per-target strobes: one strobe per event
// enable word, one for the host word, and four index strobes.
// Assumes the event words fit between EVT_WORD_BASE and HOST_WORD.
module irqen_decode
    import irqen_pkg::*;
#(
    parameter int N_EVT_WORDS  = 5,
    parameter int N_HOST_WORDS = 1
) (
    input  logic                    we,
    input  logic [ADDR_W-1:0]       addr,
    output logic [N_EVT_WORDS-1:0]  evt_word_we,
    output logic [N_HOST_WORDS-1:0] host_word_we,
    output logic                    evt_set,
    output logic                    evt_clr,
    output logic                    host_set,
    output logic                    host_clr
);
    // One comparator per event enable word.
    for (genvar w = 0; w < N_EVT_WORDS; w++) begin : g_evt_we
        assign evt_word_we[w] = we && (addr == ADDR_W'(EVT_WORD_BASE + w));
    end

    // One comparator per host enable word.
    for (genvar w = 0; w < N_HOST_WORDS; w++) begin : g_host_we
        assign host_word_we[w] = we && (addr == ADDR_W'(HOST_WORD + w));
    end

    // Index register strobes.
    always_comb begin
        evt_set  = we && (addr == ADDR_W'(EVT_SET_IDX));
        evt_clr  = we && (addr == ADDR_W'(EVT_CLR_IDX));
        host_set = we && (addr == ADDR_W'(HOST_SET_IDX));
        host_clr = we && (addr == ADDR_W'(HOST_CLR_IDX));
    end
endmodule

// File: rtl/irqen_bank.sv
// Module irqen_bank
// A bank of NBITS enable flops. Each whole bus word can be loaded
// directly, and one bit can be set or cleared by its index.
// Whole-word loads are applied first; an index update is then applied
// to that result. An index at or above NBITS is dropped. The decoder
// never raises a set and a clear in the same cycle.
module irqen_bank
    import irqen_pkg::*;
#(
    parameter int NBITS  = 160,
    parameter int NWORDS = words_for(NBITS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NWORDS-1:0] word_we,
    input  logic [DATA_W-1:0] wdata,
    input  logic              set_we,
    input  logic              clr_we,
    input  logic [IDX_W-1:0]  idx,
    output logic [NBITS-1:0]  en
);
    localparam logic [IDX_W-1:0] IDX_LIMIT = IDX_W'(NBITS);

    logic [NBITS-1:0] q;
    logic [NBITS-1:0] loaded;
    logic [NBITS-1:0] nxt;
    logic             idx_ok;

    // Keep data bits above a short bank visibly consumed.
    if (NBITS < DATA_W) begin : g_pad
        logic unused_wdata;
        assign unused_wdata = ^wdata[DATA_W-1:NBITS];
    end

    // Range check of the index against the bank size.
    assign idx_ok = (idx < IDX_LIMIT);

    // Whole-word loads: each bit takes its word's data lane when strobed.
    always_comb begin
        for (int b = 0; b < NBITS; b++) begin
            loaded[b] = word_we[b / DATA_W] ? wdata[b % DATA_W] : q[b];
        end
    end

    // Index update on top of the loaded value: one matching bit only.
    always_comb begin
        nxt = loaded;
        for (int b = 0; b < NBITS; b++) begin
            if (idx_ok && (idx == IDX_W'(b))) begin
                if (set_we) nxt[b] = 1'b1;
                if (clr_we) nxt[b] = 1'b0;
            end
        end
    end

    // Enable state register with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= nxt;
    end

    assign en = q;

    AST_RESET_CLEAR: assert property (@(posedge clk) !rst_n |=> en == '0); // R1
    AST_IDX_ONE_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        ((set_we || clr_we) && word_we == '0) |=> $countones(en ^ $past(en)) <= 1); // R2
    AST_SET_NO_LOWER: assert property (@(posedge clk) disable iff (!rst_n)
        (set_we && word_we == '0) |=> ($past(en) & ~en) == '0); // R3
    AST_CLR_NO_RAISE: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_we && word_we == '0) |=> (en & ~$past(en)) == '0); // R4
    AST_OOR_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        ((set_we || clr_we) && word_we == '0 && idx >= IDX_LIMIT) |=> $stable(en)); // R5
endmodule

// File: rtl/irqen_rdmux.sv
// Module irqen_rdmux
// Read-data selector: returns the addressed event or host enable word.
// Bits beyond the enable vectors, index registers and unmapped
// addresses read as zero. Purely combinational.
module irqen_rdmux
    import irqen_pkg::*;
#(
    parameter int N_EVT  = 160,
    parameter int N_HOST = 20
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [N_EVT-1:0]  evt_en,
    input  logic [N_HOST-1:0] host_en,
    output logic [DATA_W-1:0] rdata
);
    localparam int EVT_WORDS = words_for(N_EVT);
    localparam int EVT_PADW  = EVT_WORDS * DATA_W;

    logic [EVT_PADW-1:0] evt_pad;

    // Zero-extend the event vector to whole words.
    assign evt_pad = EVT_PADW'(evt_en);

    // Address-driven word select, zero by default.
    always_comb begin
        rdata = '0;
        for (int w = 0; w < EVT_WORDS; w++) begin
            if (addr == ADDR_W'(EVT_WORD_BASE + w)) rdata = evt_pad[w*DATA_W +: DATA_W];
        end
        if (addr == ADDR_W'(HOST_WORD)) rdata = DATA_W'(host_en);
    end
endmodule

// File: rtl/irq_enable_bank.sv
// Module irq_enable_bank (top)
// Enable register file of an interrupt controller. It holds one enable
// bit per system event and per host interrupt. Software changes the
// bits through direct word writes or through set/clear index registers.
// Host interrupt requests are gated by their enables. Assumes a single
// register bus with one write per cycle and a combinational read.
module irq_enable_bank
    import irqen_pkg::*;
#(
    parameter int N_EVT  = 160,
    parameter int N_HOST = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_we,
    input  logic [3:0]        bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic [N_HOST-1:0] host_req_i,
    output logic [N_EVT-1:0]  event_en_o,
    output logic [N_HOST-1:0] host_en_o,
    output logic [N_HOST-1:0] host_irq_o
);
    localparam int EVT_WORDS  = words_for(N_EVT);
    localparam int HOST_WORDS = words_for(N_HOST);

    logic [EVT_WORDS-1:0]  evt_word_we;
    logic [HOST_WORDS-1:0] host_word_we;
    logic                  evt_set, evt_clr, host_set, host_clr;
    logic [IDX_W-1:0]      wr_idx;

    // Index field: low bits of the write data only.
    assign wr_idx = bus_wdata[IDX_W-1:0];

    irqen_decode #(
        .N_EVT_WORDS (EVT_WORDS),
        .N_HOST_WORDS(HOST_WORDS)
    ) i_decode (
        .we          (bus_we),
        .addr        (bus_addr),
        .evt_word_we (evt_word_we),
        .host_word_we(host_word_we),
        .evt_set     (evt_set),
        .evt_clr     (evt_clr),
        .host_set    (host_set),
        .host_clr    (host_clr)
    );

    irqen_bank #(.NBITS(N_EVT), .NWORDS(EVT_WORDS)) i_evt_bank (
        .clk    (clk),
        .rst_n  (rst_n),
        .word_we(evt_word_we),
        .wdata  (bus_wdata),
        .set_we (evt_set),
        .clr_we (evt_clr),
        .idx    (wr_idx),
        .en     (event_en_o)
    );

    irqen_bank #(.NBITS(N_HOST), .NWORDS(HOST_WORDS)) i_host_bank (
        .clk    (clk),
        .rst_n  (rst_n),
        .word_we(host_word_we),
        .wdata  (bus_wdata),
        .set_we (host_set),
        .clr_we (host_clr),
        .idx    (wr_idx),
        .en     (host_en_o)
    );

    irqen_rdmux #(.N_EVT(N_EVT), .N_HOST(N_HOST)) i_rdmux (
        .addr   (bus_addr),
        .evt_en (event_en_o),
        .host_en(host_en_o),
        .rdata  (bus_rdata)
    );

    // Host interrupt gating.
    assign host_irq_o = host_req_i & host_en_o;

    AST_IRQ_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        (host_irq_o & ~host_en_o) == '0); // R8
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_we |=> ($stable(event_en_o) && $stable(host_en_o))); // R9
    AST_IDX_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr >= 4'(EVT_SET_IDX) && bus_addr <= 4'(HOST_CLR_IDX)) |-> bus_rdata == '0); // R7
endmodule

// File: tb/test_irq_enable_bank.sv
module test_irq_enable_bank;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         bus_we = 1'b0;
    logic [3:0]   bus_addr = '0;
    logic [31:0]  bus_wdata = '0;
    logic [31:0]  bus_rdata;
    logic [19:0]  host_req_i = '0;
    logic [159:0] event_en_o;
    logic [19:0]  host_en_o;
    logic [19:0]  host_irq_o;

    int vectors = 0;
    int miscompares = 0;
    logic [159:0] m_evt = '0;
    logic [19:0]  m_host = '0;

    always #2 clk = ~clk;

    irq_enable_bank i_irq_enable_bank (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .host_req_i(host_req_i),
        .event_en_o(event_en_o), .host_en_o(host_en_o), .host_irq_o(host_irq_o)
    );

    task automatic check(input string req, input logic [159:0] act, input logic [159:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Reference model of one bus write.
    task automatic model_write(input logic [3:0] a, input logic [31:0] d);
        int n;
        n = int'(d[9:0]);
        if (a <= 4'd4) m_evt[int'(a)*32 +: 32] = d;
        else if (a == 4'd5) m_host = d[19:0];
        else if (a == 4'd8 && n < 160) m_evt[n] = 1'b1;
        else if (a == 4'd9 && n < 160) m_evt[n] = 1'b0;
        else if (a == 4'd10 && n < 20) m_host[n] = 1'b1;
        else if (a == 4'd11 && n < 20) m_host[n] = 1'b0;
    endtask

    function automatic logic [31:0] model_read(input logic [3:0] a);
        if (a <= 4'd4) return m_evt[int'(a)*32 +: 32];
        if (a == 4'd5) return {12'd0, m_host};
        return 32'd0;
    endfunction

    task automatic bus_write(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
        model_write(a, d);
        #1;
    endtask

    task automatic check_state(input string req);
        check(req, event_en_o, m_evt);
        check(req, {140'd0, host_en_o}, {140'd0, m_host});
        check({req, " irq"}, {140'd0, host_irq_o}, {140'd0, host_req_i & m_host});
    endtask

    task automatic check_read(input string req, input logic [3:0] a);
        @(negedge clk);
        bus_addr = a;
        #1;
        check(req, {128'd0, bus_rdata}, {128'd0, model_read(a)});
    endtask

    initial begin
        #800000;
        miscompares++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        int seed;
        seed = $urandom(32'h1d5);
        host_req_i = '1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        check_state("R1 reset");
        check_read("R1 reset read", 4'd4);

        // R2 placement across word boundaries
        bus_write(4'd8, 32'd0);
        bus_write(4'd8, 32'd31);
        bus_write(4'd8, 32'd32);
        bus_write(4'd8, 32'd159);
        check_state("R2 event set");
        check_read("R2 word4 bit31", 4'd4);
        check_read("R2 word1 bit0", 4'd1);

        // R3 host set at both ends
        bus_write(4'd10, 32'd0);
        bus_write(4'd10, 32'd19);
        check_state("R3 host set");

        // R5 out of range and upper index bits
        bus_write(4'd8, 32'd160);
        bus_write(4'd8, 32'd1023);
        bus_write(4'd10, 32'd20);
        check_state("R5 out of range");
        bus_write(4'd8, 32'hFFFF_FC07);
        bus_write(4'd10, 32'h0000_0405);
        check_state("R5 upper bits ignored");

        // R4 clear one bit
        bus_write(4'd9, 32'd31);
        bus_write(4'd11, 32'd19);
        bus_write(4'd9, 32'd500);
        check_state("R4 clear");

        // R6 direct word loads and host truncation
        bus_write(4'd2, 32'hA5A5_0F0F);
        bus_write(4'd5, 32'hFFFF_FFFF);
        check_state("R6 word write");
        check_read("R6 host word high zero", 4'd5);

        // R7 index and unmapped reads
        check_read("R7 idx read", 4'd8);
        check_read("R7 idx read", 4'd11);
        check_read("R7 unmapped", 4'd6);
        check_read("R7 unmapped", 4'd15);

        // R8 gating with a sparse request pattern
        @(negedge clk);
        host_req_i = 20'h0_F0F1;
        #1;
        check_state("R8 gating");

        // R9 strobe low: address and data move but nothing changes
        @(negedge clk);
        bus_we = 1'b0; bus_addr = 4'd8; bus_wdata = 32'd77;
        @(negedge clk);
        bus_addr = 4'd0; bus_wdata = 32'hFFFF_FFFF;
        @(negedge clk);
        #1;
        check_state("R9 idle hold");

        // Random mix of index and word writes
        for (int i = 0; i < 400; i++) begin
            logic [3:0]  a;
            logic [31:0] d;
            int k;
            k = int'($urandom_range(0, 9));
            d = $urandom();
            if (k < 4) begin
                a = 4'(8 + k);
                if ($urandom_range(0, 3) != 0)
                    d = {d[31:10], 10'($urandom_range(0, (k < 2) ? 159 : 19))};
            end else if (k < 6) begin
                a = 4'($urandom_range(0, 5));
            end else begin
                a = 4'(8 + (k - 6));
                d = {22'd0, 10'($urandom_range(0, (k < 8) ? 159 : 19))};
            end
            host_req_i = 20'($urandom());
            bus_write(a, d);
            check_state("R2 R3 R4 R5 R6 random");
            if (i % 8 == 0) check_read("R7 random read", 4'($urandom_range(0, 15)));
        end

        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule